// File: doc/BRIEF.md
# Attribute Controller Register Port

This block holds the register file of a VGA-style attribute controller and the access logic in front of it. A single write strobe carries both register addresses and register data. An internal phase bit decides which one a given byte is. In the index phase a byte selects a register and also sets or clears the display-enable flag. The following byte in the data phase is stored into the selected register. A read of the input status port returns the phase bit to the index phase, so software can always resynchronise.

The block holds these registers:
- sixteen palette entries,
- a mode register,
- a border colour,
- a plane mask,
- a raw pixel-panning value,
- a colour select.

Every held value is available on an output. So is an effective panning shift, which depends on whether the display is in text mode. A one-cycle pulse tells the downstream palette logic that its lookup must be rebuilt. Two combinational read ports return the current index byte and the currently selected register.

Top module: `attr_ctrl_regs`

## Requirements
- R1: After reset:
  - the phase is index,
  - the stored index is 0 and the enable flag is 1,
  - every register is 0,
  - `remap_o` is 0.
- R2: A write in the index phase stores `wr_data_i[4:0]` as the index and `wr_data_i[5]` as the enable flag, then moves to the data phase.
- R3: A write in the data phase stores the byte into the register chosen by the stored index. It leaves the index unchanged and returns to the index phase.
- R4: `idx_rdata_o` equals `{2'b00, enable, index[4:0]}` at all times.
- R5: Palette entries occupy indices 0x00–0x0F and hold the low 6 data bits; they read back zero-extended. A data write to a palette index is ignored while the enable flag is 1.
- R6: Indices 0x10–0x14 hold full bytes, are written regardless of the enable flag, and drive their own outputs:
  - 0x10 drives `mode_o`,
  - 0x11 drives `overscan_o`,
  - 0x12 drives `plane_en_o`,
  - 0x13 drives `pan_raw_o`,
  - 0x14 drives `color_sel_o`.
- R7: Data writes to indices 0x15–0x1F change no register, and `data_rdata_o` reads 0 for those indices.
- R8: With `text_mode_i` = 1, `pan_eff_o` is 0 when the panning register exceeds 7, and the register value plus one otherwise.
- R9: With `text_mode_i` = 0, `pan_eff_o` is the low three bits of the panning register.
- R10: A status read forces the index phase. If it coincides with a write, the write is handled under the old phase and the phase still ends at index.
- R11: `remap_o` is high for exactly the one cycle after a data write that either:
  - changes bit 7 of the mode register, or
  - changes any bit of the colour select register.
  Writes that leave these bits unchanged, or that go to other registers, give no pulse.
- R12: `disp_en_o` follows the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe on the shared index/data port |
| wr_data_i | input | 8 | Write byte |
| status_rd_i | input | 1 | Input status read strobe; forces the index phase |
| text_mode_i | input | 1 | Selects the text-mode panning remap |
| idx_rdata_o | output | 8 | Index read value |
| data_rdata_o | output | 8 | Selected register read value |
| pal_flat_o | output | 96 | Palette entries, entry n at bits [6n+5:6n] |
| mode_o | output | 8 | Mode register |
| overscan_o | output | 8 | Border colour |
| plane_en_o | output | 8 | Plane mask |
| pan_raw_o | output | 8 | Raw panning register |
| pan_eff_o | output | 4 | Effective panning shift |
| color_sel_o | output | 8 | Colour select |
| disp_en_o | output | 1 | Display-enable flag |
| remap_o | output | 1 | Palette-recompute pulse |

## Verification
A phase bit that is stuck or slipped shows up on the very next write: a data byte lands as an index and is visible at once in `idx_rdata_o`. A wrong write gate shows up on the next readback through `data_rdata_o`: a palette entry that changed while locked, or a reserved index that returned a value. A change detector compared against the new value instead of the old one shows as a missing or extra `remap_o` pulse in the single cycle after the data write. Panning faults appear immediately on `pan_eff_o`, because the bench sweeps every register value in both modes.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int IDX_W  = 5;
  localparam int EN_BIT = 5;
  localparam int MODE_REMAP_BIT = 7;

  localparam logic [IDX_W-1:0] IDX_MODE  = 5'h10;
  localparam logic [IDX_W-1:0] IDX_OVSC  = 5'h11;
  localparam logic [IDX_W-1:0] IDX_PLANE = 5'h12;
  localparam logic [IDX_W-1:0] IDX_PAN   = 5'h13;
  localparam logic [IDX_W-1:0] IDX_CSEL  = 5'h14;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
  import attr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W:0]   ctrl_i,
  input  logic             status_rd_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             en_o,
  output logic             data_we_o
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INDEX;
      idx_q   <= '0;
      en_q    <= 1'b1;
    end else begin
      if (wr_en_i) begin
        if (phase_q == PH_INDEX) begin
          idx_q   <= ctrl_i[IDX_W-1:0];
          en_q    <= ctrl_i[EN_BIT];
          phase_q <= PH_DATA;
        end else begin
          phase_q <= PH_INDEX;
        end
      end
      // status read wins over the toggle
      if (status_rd_i) phase_q <= PH_INDEX;
    end
  end

  assign idx_o     = idx_q;
  assign en_o      = en_q;
  assign data_we_o = wr_en_i && (phase_q == PH_DATA);

  p_idx_to_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_rd_i && phase_q == PH_INDEX) |=> (phase_q == PH_DATA));
  p_data_to_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> (phase_q == PH_INDEX));
  p_idx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> ($stable(idx_q) && $stable(en_q)));
  p_status_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (phase_q == PH_INDEX));
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_PAL = 16,
  parameter int PAL_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     en_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NUM_PAL*PAL_W-1:0] pal_flat_o,
  output logic [DW-1:0]            mode_o,
  output logic [DW-1:0]            ovsc_o,
  output logic [DW-1:0]            plane_o,
  output logic [DW-1:0]            pan_o,
  output logic [DW-1:0]            csel_o,
  output logic [DW-1:0]            rdata_o
);
  localparam int PAL_AW = $clog2(NUM_PAL);

  logic [PAL_W-1:0] pal_q [NUM_PAL];
  logic [DW-1:0] mode_q, ovsc_q, plane_q, pan_q, csel_q;
  logic pal_wr_ok;

  assign pal_wr_ok = we_i && !en_i;

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     pal_q[g] <= '0;
      else if (pal_wr_ok && idx_i == IDX_W'(g))        pal_q[g] <= wdata_i[PAL_W-1:0];
    end
    assign pal_flat_o[g*PAL_W +: PAL_W] = pal_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ovsc_q  <= '0;
      plane_q <= '0;
      pan_q   <= '0;
      csel_q  <= '0;
    end else if (we_i) begin
      unique case (idx_i)
        IDX_MODE:  mode_q  <= wdata_i;
        IDX_OVSC:  ovsc_q  <= wdata_i;
        IDX_PLANE: plane_q <= wdata_i;
        IDX_PAN:   pan_q   <= wdata_i;
        IDX_CSEL:  csel_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i < IDX_W'(NUM_PAL)) begin
      rdata_o = DW'(pal_q[idx_i[PAL_AW-1:0]]);
    end else begin
      case (idx_i)
        IDX_MODE:  rdata_o = mode_q;
        IDX_OVSC:  rdata_o = ovsc_q;
        IDX_PLANE: rdata_o = plane_q;
        IDX_PAN:   rdata_o = pan_q;
        IDX_CSEL:  rdata_o = csel_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign ovsc_o  = ovsc_q;
  assign plane_o = plane_q;
  assign pan_o   = pan_q;
  assign csel_o  = csel_q;

  p_pal_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && en_i && idx_i < IDX_W'(NUM_PAL)) |=> $stable(pal_flat_o));
  p_undef_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i > IDX_CSEL) |=>
      ($stable(pal_flat_o) && $stable({mode_q, ovsc_q, plane_q, pan_q, csel_q})));
endmodule

// File: rtl/attr_pan_map.sv
module attr_pan_map #(
  parameter int DW      = 8,
  parameter int SHIFT_W = 4
) (
  input  logic [DW-1:0]      pan_raw_i,
  input  logic               text_mode_i,
  output logic [SHIFT_W-1:0] pan_eff_o
);
  localparam int TEXT_MAX = 7;

  always_comb begin
    if (text_mode_i) begin
      if (pan_raw_i > DW'(TEXT_MAX)) pan_eff_o = '0;
      else                           pan_eff_o = SHIFT_W'(pan_raw_i[2:0]) + SHIFT_W'(1);
    end else begin
      pan_eff_o = SHIFT_W'(pan_raw_i[2:0]);
    end
  end
endmodule

// File: rtl/attr_remap_det.sv
module attr_remap_det
  import attr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    mode_i,
  input  logic [DW-1:0]    csel_i,
  output logic             pulse_o
);
  logic trig, pulse_q;

  // compare against the value held before this write
  assign trig = we_i &&
    (((idx_i == IDX_MODE) && (wdata_i[MODE_REMAP_BIT] != mode_i[MODE_REMAP_BIT])) ||
     ((idx_i == IDX_CSEL) && (wdata_i != csel_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= trig;
  end

  assign pulse_o = pulse_q;

  p_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  p_pulse_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(we_i) &&
                 ($past(idx_i) == IDX_MODE || $past(idx_i) == IDX_CSEL)));
endmodule

// File: rtl/attr_ctrl_regs.sv
module attr_ctrl_regs
  import attr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_PAL = 16,
  parameter int PAL_W   = 6,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     status_rd_i,
  input  logic                     text_mode_i,
  output logic [DW-1:0]            idx_rdata_o,
  output logic [DW-1:0]            data_rdata_o,
  output logic [NUM_PAL*PAL_W-1:0] pal_flat_o,
  output logic [DW-1:0]            mode_o,
  output logic [DW-1:0]            overscan_o,
  output logic [DW-1:0]            plane_en_o,
  output logic [DW-1:0]            pan_raw_o,
  output logic [SHIFT_W-1:0]       pan_eff_o,
  output logic [DW-1:0]            color_sel_o,
  output logic                     disp_en_o,
  output logic                     remap_o
);
  logic [IDX_W-1:0] idx;
  logic             en;
  logic             data_we;

  attr_phase_ctl u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .ctrl_i      (wr_data_i[IDX_W:0]),
    .status_rd_i (status_rd_i),
    .idx_o       (idx),
    .en_o        (en),
    .data_we_o   (data_we)
  );

  attr_regfile #(.DW(DW), .NUM_PAL(NUM_PAL), .PAL_W(PAL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (data_we),
    .idx_i      (idx),
    .en_i       (en),
    .wdata_i    (wr_data_i),
    .pal_flat_o (pal_flat_o),
    .mode_o     (mode_o),
    .ovsc_o     (overscan_o),
    .plane_o    (plane_en_o),
    .pan_o      (pan_raw_o),
    .csel_o     (color_sel_o),
    .rdata_o    (data_rdata_o)
  );

  attr_pan_map #(.DW(DW), .SHIFT_W(SHIFT_W)) u_pan (
    .pan_raw_i   (pan_raw_o),
    .text_mode_i (text_mode_i),
    .pan_eff_o   (pan_eff_o)
  );

  attr_remap_det #(.DW(DW)) u_remap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we),
    .idx_i   (idx),
    .wdata_i (wr_data_i),
    .mode_i  (mode_o),
    .csel_i  (color_sel_o),
    .pulse_o (remap_o)
  );

  assign idx_rdata_o = DW'({en, idx});
  assign disp_en_o   = en;

  p_text_pan_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    text_mode_i |-> (pan_eff_o <= SHIFT_W'(8)));
endmodule

// File: tb/attr_ctrl_regs_test.sv
module attr_ctrl_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic status_rd = 1'b0;
  logic text_mode = 1'b0;
  logic [7:0] idx_rdata, data_rdata, mode, ovsc, plane, pan_raw, csel;
  logic [95:0] pal_flat;
  logic [3:0] pan_eff;
  logic disp_en, remap;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] model [32];
  logic en_m = 1'b1;

  always #2.5 clk = ~clk;

  attr_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_rd_i(status_rd), .text_mode_i(text_mode),
    .idx_rdata_o(idx_rdata), .data_rdata_o(data_rdata), .pal_flat_o(pal_flat),
    .mode_o(mode), .overscan_o(ovsc), .plane_en_o(plane), .pan_raw_o(pan_raw),
    .pan_eff_o(pan_eff), .color_sel_o(csel), .disp_en_o(disp_en), .remap_o(remap)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic srd();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  // index byte then data byte, with model update
  task automatic setreg(logic [4:0] i, logic en, logic [7:0] v);
    wr({2'b00, en, i});
    en_m = en;
    wr(v);
    if (i < 5'h10) begin
      if (!en) model[i] = {2'b00, v[5:0]};
    end else if (i <= 5'h14) model[i] = v;
  endtask

  task automatic readreg(logic [4:0] i, logic en, string req);
    wr({2'b00, en, i});
    en_m = en;
    chk("R4 index readback", idx_rdata, {2'b00, en, i});
    chk(req, data_rdata, model[i]);
    srd();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 index byte", idx_rdata, 8'h20);
    chk("R1 data", data_rdata, 8'h00);
    chk("R1 palette", pal_flat, 96'h0);
    chk("R1 regs", {mode, ovsc, plane, pan_raw, csel}, 40'h0);
    chk("R1 remap", remap, 1'b0);
    chk("R12 disp_en reset", disp_en, 1'b1);

    // R2 index write moves to data phase: next byte is data, not index
    wr(8'h03);
    chk("R2 index stored", idx_rdata, 8'h03);
    chk("R12 disp_en cleared", disp_en, 1'b0);
    wr(8'h15);
    model[3] = 8'h15;
    chk("R3 data landed", data_rdata, 8'h15);
    chk("R3 index kept", idx_rdata, 8'h03);
    wr(8'h07);
    chk("R3 back to index phase", idx_rdata, 8'h07);
    srd();

    // R3 R5 R6 R7 sweep with enable clear
    for (int i = 0; i < 32; i++) setreg(5'(i), 1'b0, 8'((i * 37 + 11) & 255));
    for (int i = 0; i < 32; i++) begin
      if (i < 16)      readreg(5'(i), 1'b0, "R5 palette readback");
      else if (i < 21) readreg(5'(i), 1'b0, "R6 control readback");
      else             readreg(5'(i), 1'b0, "R7 undefined reads zero");
    end
    for (int i = 0; i < 16; i++)
      chk("R5 palette output", pal_flat[i*6 +: 6], model[i][5:0]);
    chk("R6 mode_o", mode, model[16]);
    chk("R6 overscan_o", ovsc, model[17]);
    chk("R6 plane_en_o", plane, model[18]);
    chk("R6 pan_raw_o", pan_raw, model[19]);
    chk("R6 color_sel_o", csel, model[20]);

    // R5 lock: enable set, palette writes ignored, control regs still written
    for (int i = 0; i < 16; i++) setreg(5'(i), 1'b1, ~model[i]);
    chk("R12 disp_en set", disp_en, 1'b1);
    for (int i = 0; i < 16; i++) readreg(5'(i), 1'b1, "R5 locked palette unchanged");
    setreg(5'h12, 1'b1, 8'hA5);
    readreg(5'h12, 1'b1, "R6 write with enable set");

    // R8 R9 panning sweep
    for (int v = 0; v < 256; v++) begin
      setreg(5'h13, 1'b1, 8'(v));
      text_mode = 1'b1;
      #1;
      chk("R8 text pan", pan_eff, (v > 7) ? 4'd0 : 4'(v + 1));
      text_mode = 1'b0;
      #1;
      chk("R9 graphics pan", pan_eff, 4'(v & 7));
    end

    // R10 status read coinciding with an index write
    wr_en = 1'b1; wr_data = 8'h12; status_rd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; status_rd = 1'b0;
    chk("R10 index taken", idx_rdata, 8'h12);
    wr(8'h25);
    chk("R10 next byte is index", idx_rdata, 8'h25);
    // status read in data phase
    srd();
    wr(8'h04);
    chk("R10 after status read", idx_rdata, 8'h04);
    srd();

    // R11 remap pulse
    setreg(5'h10, 1'b1, 8'h00);
    @(negedge clk);
    wr(8'h30);
    wr(8'h80);
    chk("R11 mode bit7 rise pulse", remap, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", remap, 1'b0);
    wr(8'h30); wr(8'h80);
    chk("R11 same mode no pulse", remap, 1'b0);
    wr(8'h30); wr(8'h81);
    chk("R11 low bit change no pulse", remap, 1'b0);
    wr(8'h30); wr(8'h01);
    chk("R11 mode bit7 fall pulse", remap, 1'b1);
    wr(8'h34); wr(8'h00);
    @(negedge clk);
    wr(8'h34); wr(8'h00);
    chk("R11 csel unchanged no pulse", remap, 1'b0);
    wr(8'h34); wr(8'h02);
    chk("R11 csel change pulse", remap, 1'b1);
    wr(8'h31); wr(8'h3C);
    chk("R11 overscan no pulse", remap, 1'b0);
    wr(8'h1A); wr(8'h55);
    chk("R11 undefined no pulse", remap, 1'b0);

    summary();
  end
endmodule